// File: doc/BRIEF.md
# Mixed-Width Register Access Adapter

This block sits between a processor-side bus master and a peripheral register space in which each register is 8, 16 or 32 bits wide. The master may issue byte, halfword or word accesses at any offset. The adapter looks up the native width of the addressed 4-byte granule in a width map. It then converts the request into the native-width accesses that the register space accepts, issuing one per clock.

A request wider than the native registers is split into consecutive native accesses at ascending offsets, with the lowest offset carrying the most significant part. A read narrower than the native register fetches the enclosing register and extracts the addressed lanes. A write narrower than the native register becomes a read of the enclosing register, a merge and a write-back. Byte order is big-endian throughout. Offsets outside the implemented window, and granules mapped as absent, end the request with an error flag and no register traffic.

Top module: `width_adapter`

## Requirements
- R1: Only the low 10 bits of `req_addr` form the offset; higher bits are ignored. The offset is also forced to the alignment of the request size by clearing its low bits. `req_size` codes are 0 byte, 1 halfword, 2 word, and code 3 acts as word.
- R2: An aligned offset of 0x200 or above, or one in a granule mapped absent, finishes with `rsp_err`=1 and `rsp_rdata`=0. It makes no register access, and `rsp_done` is high in the cycle right after the accepting edge.
- R3: Granule g covers offsets 4g to 4g+3, and its 2-bit code sits at `WIDTH_MAP[2g+1:2g]` with 0 absent, 1 byte, 2 halfword, 3 word. The default map sets granule g by ((g>>4)&3): 0 gives byte, 1 halfword, 2 word, 3 absent. Every register access uses its granule's width code minus one as `reg_size` and an address aligned to that width.
- R4: A request whose size equals the native width makes exactly one register access at the aligned offset. Read data is returned right-justified.
- R5: A read narrower than the native register makes one read of the enclosing register. It returns the addressed bytes in big-endian order: the lowest offset is the most significant byte.
- R6: A read wider than the native register makes size/width consecutive reads at ascending offsets. The first result forms the most significant part.
- R7: A write wider than the native register makes size/width consecutive writes at ascending offsets. The first write carries the most significant part of `req_wdata`.
- R8: A write narrower than the native register reads the enclosing register, replaces only the addressed bytes, and writes it back to the same address. All other bytes of that register keep their value.
- R9: Register accesses occur on consecutive cycles. `rsp_done` pulses for one cycle, N clock edges after the accepting edge, where N is the number of register accesses. `rsp_rdata` and `rsp_err` are valid while `rsp_done` is high, and `rsp_rdata` is 0 for writes.
- R10: `req_ready` is high exactly when no request is in progress, including out of reset. No register access is made while `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Adapter idle, request accepted on this edge |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_addr | input | ADDR_W | Byte offset (low 10 bits used) |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion with error |
| rsp_rdata | output | 32 | Read data, right-justified |
| reg_en | output | 1 | Register access strobe |
| reg_we | output | 1 | Register access is a write |
| reg_size | output | 2 | Native width code of the access |
| reg_addr | output | 10 | Register byte offset |
| reg_wdata | output | 32 | Register write data, right-justified |
| reg_rdata | input | 32 | Register read data, same cycle, right-justified |

## Verification
A wrong remaining-count or state register shows up as an extra or missing register strobe, and as a `rsp_done` pulse that lands earlier or later than the expected number of edges. The latency check and the strobe count catch this in the same transaction. A wrong shift or merge control shows up as misplaced bytes in read data when `rsp_done` rises. For writes it shows up as corrupted neighbour bytes in the register model, which the bench compares right after completion. A wrong width lookup shows up at once on `reg_size` during the first register access.

// File: rtl/wadp_pkg.sv
package wadp_pkg;

    localparam int OFFS_W = 10;
    localparam int LIMIT  = 512;
    localparam int GRANS  = LIMIT / 4;
    localparam int GI_W   = $clog2(GRANS);
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        WC_NONE = 2'd0,
        WC_BYTE = 2'd1,
        WC_HALF = 2'd2,
        WC_WORD = 2'd3
    } wcode_e;

    typedef enum logic [1:0] {
        PM_DIRECT = 2'd0,
        PM_SPLIT  = 2'd1,
        PM_NARROW = 2'd2
    } pmode_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READ   = 3'd1,
        ST_WRITE  = 3'd2,
        ST_RMW_RD = 3'd3,
        ST_RMW_WR = 3'd4
    } state_e;

    typedef struct packed {
        logic              err;
        pmode_e            mode;
        logic [1:0]        rsz;
        logic [1:0]        nsz;
        logic [2:0]        nacc;
        logic [1:0]        shb;
        logic [OFFS_W-1:0] base;
    } plan_t;

    // Default granule map: bands of 16 granules cycle byte, half, word, absent.
    function automatic logic [2*GRANS-1:0] default_map();
        logic [2*GRANS-1:0] m;
        m = '0;
        for (int g = 0; g < GRANS; g++) begin
            case ((g >> 4) & 3)
                0:       m[2*g +: 2] = WC_BYTE;
                1:       m[2*g +: 2] = WC_HALF;
                2:       m[2*g +: 2] = WC_WORD;
                default: m[2*g +: 2] = WC_NONE;
            endcase
        end
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(input logic [1:0] lg);
        case (lg)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/wadp_plan.sv
module wadp_plan
    import wadp_pkg::*;
#(
    parameter int                 ADDR_W    = 12,
    parameter logic [2*GRANS-1:0] WIDTH_MAP = default_map()
) (
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    output plan_t             plan
);

    logic [1:0]        sz;
    logic [OFFS_W-1:0] off_al;
    logic              oor;
    logic [GI_W-1:0]   gidx;
    wcode_e            wc;
    logic [2:0]        wb;
    logic [2:0]        sb;
    logic [1:0]        sub;

    always_comb begin
        sz     = (req_size == 2'd3) ? 2'd2 : req_size;
        off_al = req_addr[OFFS_W-1:0] & ~(OFFS_W'((32'd1 << sz) - 32'd1));
        oor    = ({22'd0, off_al} >= 32'(LIMIT));
        gidx   = off_al[GI_W+1:2];
        wc     = oor ? WC_NONE : wcode_e'(WIDTH_MAP[2*gidx +: 2]);

        plan      = '0;
        plan.err  = (wc == WC_NONE);
        plan.rsz  = sz;
        plan.nsz  = 2'(wc) - 2'd1;
        wb        = 3'(3'd1 << plan.nsz);
        sb        = 3'(3'd1 << sz);
        sub       = off_al[1:0] & 2'(wb - 3'd1);
        plan.base = off_al;
        plan.nacc = 3'd1;
        plan.mode = PM_DIRECT;
        plan.shb  = 2'd0;

        if (!plan.err) begin
            if (sz > plan.nsz) begin
                plan.mode = PM_SPLIT;
                plan.nacc = 3'(3'd1 << (sz - plan.nsz));
            end else if (sz < plan.nsz) begin
                plan.mode = PM_NARROW;
                plan.base = off_al & ~(OFFS_W'(wb - 3'd1));
                plan.shb  = 2'(wb - sb - {1'b0, sub});
                plan.nacc = req_write ? 3'd2 : 3'd1;
            end
        end
    end

endmodule

// File: rtl/wadp_lanes.sv
module wadp_lanes
    import wadp_pkg::*;
(
    input  logic [1:0]        nsz,
    input  logic [1:0]        rsz,
    input  logic [1:0]        shb,
    input  logic [2:0]        rem,
    input  logic [DATA_W-1:0] acc_q,
    input  logic [DATA_W-1:0] wdata_q,
    input  logic [DATA_W-1:0] rd_in,
    output logic [DATA_W-1:0] acc_nx,
    output logic [DATA_W-1:0] rd_ext,
    output logic [DATA_W-1:0] wr_merge,
    output logic [DATA_W-1:0] wr_chunk
);

    logic [5:0]        lane_sh;
    logic [5:0]        chunk_sh;
    logic [DATA_W-1:0] field;
    logic [DATA_W-1:0] acc_shift;

    always_comb begin
        // Gather: earlier parts move up by one native width.
        case (nsz)
            2'd0:    acc_shift = acc_q << 8;
            2'd1:    acc_shift = acc_q << 16;
            default: acc_shift = '0;
        endcase
        acc_nx = acc_shift | (rd_in & lane_mask(nsz));

        // Extract the requested lanes from the gathered value.
        lane_sh = {1'b0, shb, 3'b000};
        rd_ext  = (acc_nx >> lane_sh) & lane_mask(rsz);

        // Merge new lanes into the fetched register value.
        field    = lane_mask(rsz) << lane_sh;
        wr_merge = (acc_q & ~field) | ((wdata_q & lane_mask(rsz)) << lane_sh);

        // Slice the part for the current split write, high part first.
        chunk_sh = 6'(6'(rem - 3'd1) << (6'd3 + {4'd0, nsz}));
        wr_chunk = (wdata_q >> chunk_sh) & lane_mask(nsz);
    end

endmodule

// File: rtl/width_adapter.sv
module width_adapter
    import wadp_pkg::*;
#(
    parameter int                 ADDR_W    = 12,
    parameter logic [2*GRANS-1:0] WIDTH_MAP = default_map()
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic              reg_en,
    output logic              reg_we,
    output logic [1:0]        reg_size,
    output logic [9:0]        reg_addr,
    output logic [31:0]       reg_wdata,
    input  logic [31:0]       reg_rdata
);

    typedef struct packed {
        state_e            state;
        logic [OFFS_W-1:0] addr;
        logic [2:0]        rem;
        logic [1:0]        nsz;
        logic [1:0]        rsz;
        logic [1:0]        shb;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] acc;
        logic              done;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t             r_d, r_q;
    plan_t             plan;
    logic [DATA_W-1:0] acc_nx, rd_ext, wr_merge, wr_chunk;
    logic [OFFS_W-1:0] step;
    logic              last;

    wadp_plan #(
        .ADDR_W    (ADDR_W),
        .WIDTH_MAP (WIDTH_MAP)
    ) u_plan (
        .req_write (req_write),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .plan      (plan)
    );

    wadp_lanes u_lanes (
        .nsz      (r_q.nsz),
        .rsz      (r_q.rsz),
        .shb      (r_q.shb),
        .rem      (r_q.rem),
        .acc_q    (r_q.acc),
        .wdata_q  (r_q.wdata),
        .rd_in    (reg_rdata),
        .acc_nx   (acc_nx),
        .rd_ext   (rd_ext),
        .wr_merge (wr_merge),
        .wr_chunk (wr_chunk)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        reg_en    = 1'b0;
        reg_we    = 1'b0;
        reg_addr  = r_q.addr;
        reg_size  = r_q.nsz;
        reg_wdata = '0;
        step      = OFFS_W'(10'd1 << r_q.nsz);
        last      = (r_q.rem == 3'd1);

        case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (plan.err) begin
                        r_d.done  = 1'b1;
                        r_d.err   = 1'b1;
                        r_d.rdata = '0;
                    end else begin
                        r_d.err   = 1'b0;
                        r_d.addr  = plan.base;
                        r_d.rem   = plan.nacc;
                        r_d.nsz   = plan.nsz;
                        r_d.rsz   = plan.rsz;
                        r_d.shb   = plan.shb;
                        r_d.wdata = req_wdata;
                        r_d.acc   = '0;
                        if (!req_write)
                            r_d.state = ST_READ;
                        else if (plan.mode == PM_NARROW)
                            r_d.state = ST_RMW_RD;
                        else
                            r_d.state = ST_WRITE;
                    end
                end
            end
            ST_READ: begin
                reg_en   = 1'b1;
                r_d.acc  = acc_nx;
                r_d.addr = r_q.addr + step;
                r_d.rem  = r_q.rem - 3'd1;
                if (last) begin
                    r_d.done  = 1'b1;
                    r_d.rdata = rd_ext;
                    r_d.state = ST_IDLE;
                end
            end
            ST_WRITE: begin
                reg_en    = 1'b1;
                reg_we    = 1'b1;
                reg_wdata = wr_chunk;
                r_d.addr  = r_q.addr + step;
                r_d.rem   = r_q.rem - 3'd1;
                if (last) begin
                    r_d.done  = 1'b1;
                    r_d.rdata = '0;
                    r_d.state = ST_IDLE;
                end
            end
            ST_RMW_RD: begin
                reg_en    = 1'b1;
                r_d.acc   = acc_nx;
                r_d.state = ST_RMW_WR;
            end
            ST_RMW_WR: begin
                reg_en    = 1'b1;
                reg_we    = 1'b1;
                reg_wdata = wr_merge;
                r_d.done  = 1'b1;
                r_d.rdata = '0;
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.state == ST_IDLE);
    assign rsp_done  = r_q.done;
    assign rsp_err   = r_q.err;
    assign rsp_rdata = r_q.rdata;

endmodule

// File: rtl/wadp_checker.sv
module wadp_checker
    import wadp_pkg::*;
#(
    parameter int                 ADDR_W    = 12,
    parameter logic [2*GRANS-1:0] WIDTH_MAP = default_map()
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [1:0]        req_size,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic              rsp_done,
    input logic              rsp_err,
    input logic [31:0]       rsp_rdata,
    input logic              reg_en,
    input logic              reg_we,
    input logic [1:0]        reg_size,
    input logic [9:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata
);

    function automatic logic [1:0] code_at(input logic [9:0] off);
        if (off[9]) return 2'd0;
        return WIDTH_MAP[2*off[8:2] +: 2];
    endfunction

    logic [1:0] rq_sz;
    logic [9:0] rq_off;
    logic       rq_bad;
    logic [1:0] reg_code;

    always_comb begin
        rq_sz    = (req_size == 2'd3) ? 2'd2 : req_size;
        rq_off   = req_addr[9:0] & ~(10'((11'd1 << rq_sz) - 11'd1));
        rq_bad   = (code_at(rq_off) == 2'd0);
        reg_code = code_at(reg_addr);
    end

    AST_NATIVE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        reg_en |-> (reg_code != 2'd0) && (reg_size == reg_code - 2'd1)); // R3

    AST_NATIVE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        reg_en |-> ((reg_addr & 10'((11'd1 << reg_size) - 11'd1)) == 10'd0)); // R3

    AST_BAD_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && rq_bad) |=> (rsp_done && rsp_err && !reg_en)); // R2

    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_err) |-> (rsp_rdata == 32'd0)); // R2

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        reg_en |-> !req_ready); // R10

    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (req_ready && !reg_en)); // R9

    AST_RMW_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && !reg_we && req_write && !req_ready && $past(req_ready)) |=>
        (!reg_en || reg_we)); // R8

endmodule

bind width_adapter wadp_checker #(
    .ADDR_W    (ADDR_W),
    .WIDTH_MAP (WIDTH_MAP)
) u_chk (.*);

// File: tb/width_adapter_tb.sv
module width_adapter_tb;
    import wadp_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_done, rsp_err;
    logic [31:0] rsp_rdata;
    logic        reg_en, reg_we;
    logic [1:0]  reg_size;
    logic [9:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;

    int total = 0;
    int fails = 0;
    int nat_cnt;
    int bad_sz;
    logic [7:0] mem    [0:511];
    logic [7:0] shadow [0:511];

    always #2 clk = ~clk;

    width_adapter u_dut (.*);

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    // Width code per offset (R3): 0 absent, 1 byte, 2 half, 3 word.
    function automatic int tb_code(input logic [9:0] off);
        if (off >= 10'd512) return 0;
        case (off[7:6])
            2'd0:    return 1;
            2'd1:    return 2;
            2'd2:    return 3;
            default: return 0;
        endcase
    endfunction

    // Register model
    always_comb begin
        logic [8:0] a;
        a = reg_addr[8:0];
        case (reg_size)
            2'd0:    reg_rdata = {24'd0, mem[a]};
            2'd1:    reg_rdata = {16'd0, mem[a], mem[9'(a + 9'd1)]};
            default: reg_rdata = {mem[a], mem[9'(a + 9'd1)], mem[9'(a + 9'd2)], mem[9'(a + 9'd3)]};
        endcase
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) mem[i] <= pat(i);
            nat_cnt <= 0;
            bad_sz  <= 0;
        end else if (reg_en) begin
            nat_cnt <= nat_cnt + 1;
            if (int'(reg_size) != tb_code(reg_addr) - 1) bad_sz <= bad_sz + 1;
            if (reg_we) begin
                case (reg_size)
                    2'd0: mem[reg_addr[8:0]] <= reg_wdata[7:0];
                    2'd1: begin
                        mem[reg_addr[8:0]]      <= reg_wdata[15:8];
                        mem[reg_addr[8:0] + 1]  <= reg_wdata[7:0];
                    end
                    default: begin
                        mem[reg_addr[8:0]]      <= reg_wdata[31:24];
                        mem[reg_addr[8:0] + 1]  <= reg_wdata[23:16];
                        mem[reg_addr[8:0] + 2]  <= reg_wdata[15:8];
                        mem[reg_addr[8:0] + 3]  <= reg_wdata[7:0];
                    end
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input logic wr, input logic [1:0] sz, input logic [11:0] addr, input logic [31:0] wd);
        int szc, sb, wc, wb, nexp, lat, n0;
        logic [9:0] off;
        logic [31:0] e;
        bit bad;
        string tag;
        szc = (sz == 2'd3) ? 2 : int'(sz);
        sb  = 1 << szc;
        off = addr[9:0] & ~10'(sb - 1);
        wc  = tb_code(off);
        bad = (wc == 0);
        wb  = bad ? 1 : (1 << (wc - 1));
        if (bad)            begin nexp = 0;                  tag = "R2"; end
        else if (sb > wb)   begin nexp = sb / wb;            tag = wr ? "R7" : "R6"; end
        else if (sb < wb)   begin nexp = wr ? 2 : 1;         tag = wr ? "R8" : "R5"; end
        else                begin nexp = 1;                  tag = "R4"; end
        e = '0;
        if (!bad) for (int k = 0; k < sb; k++) e = (e << 8) | 32'(shadow[off + 10'(k)]);

        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = addr; req_wdata = wd;
        @(posedge clk); #1;
        req_valid = 1'b0;
        n0 = nat_cnt;
        if (!bad) chk(req_ready == 1'b0, "R10 busy", 32'(req_ready), 32'd0);
        lat = 0;
        while (!rsp_done && lat < 16) begin
            @(posedge clk); #1;
            lat++;
        end
        chk(rsp_done == 1'b1, "R9 done seen", 32'(rsp_done), 32'd1);
        chk(lat == nexp, "R9 latency", 32'(lat), 32'(nexp));
        chk(nat_cnt - n0 == nexp, {tag, " access count"}, 32'(nat_cnt - n0), 32'(nexp));
        chk(rsp_err == bad, {tag, " err"}, 32'(rsp_err), 32'(bad));
        if (wr || bad)
            chk(rsp_rdata == 32'd0, {tag, " zero rdata"}, rsp_rdata, 32'd0);
        else
            chk(rsp_rdata == e, {tag, " rdata"}, rsp_rdata, e);
        if (wr && !bad) begin
            for (int k = 0; k < sb; k++) shadow[off + 10'(k)] = wd[8*(sb-1-k) +: 8];
            for (int k = 0; k < 4; k++) begin
                logic [9:0] b;
                b = (off & 10'h3FC) + 10'(k);
                chk(mem[b[8:0]] == shadow[b[8:0]], {tag, " register bytes"}, 32'(mem[b[8:0]]), 32'(shadow[b[8:0]]));
            end
        end
    endtask

    initial begin
        #(200000 * 4);
        fails++; total++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int unused;
        unused = $urandom(32'h0000_5EED);
        for (int i = 0; i < 512; i++) shadow[i] = pat(i);
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R10: idle and quiet in reset
        chk(req_ready == 1'b1, "R10 reset ready", 32'(req_ready), 32'd1);
        chk(rsp_done == 1'b0, "R9 reset done", 32'(rsp_done), 32'd0);
        chk(reg_en == 1'b0, "R10 reset strobe", 32'(reg_en), 32'd0);
        chk(rsp_rdata == 32'd0, "R9 reset rdata", rsp_rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corners
        run(1'b0, 2'd0, 12'h040, '0);           // R5 even byte of half reg
        run(1'b0, 2'd0, 12'h041, '0);           // R5 odd byte
        run(1'b0, 2'd1, 12'h080, '0);           // R5 upper half of word
        run(1'b0, 2'd1, 12'h082, '0);           // R5 lower half
        run(1'b0, 2'd0, 12'h0A3, '0);           // R5 lowest byte of word
        run(1'b0, 2'd2, 12'h010, '0);           // R6 word from bytes
        run(1'b0, 2'd2, 12'h044, '0);           // R6 word from halves
        run(1'b0, 2'd1, 12'h020, '0);           // R6 half from bytes
        run(1'b1, 2'd0, 12'h0A3, 32'h0000_00C3); // R8 byte into word
        run(1'b1, 2'd1, 12'h0B0, 32'h0000_1234); // R8 half into word
        run(1'b1, 2'd0, 12'h05E, 32'h0000_0077); // R8 byte into half
        run(1'b1, 2'd1, 12'h012, 32'h0000_ABCD); // R7 half to bytes
        run(1'b1, 2'd2, 12'h034, 32'h1122_3344); // R7 word to bytes
        run(1'b1, 2'd3, 12'h068, 32'h5566_7788); // R7 size code 3 acts as word
        run(1'b1, 2'd2, 12'h09C, 32'hDEAD_BEEF); // R4 direct word
        run(1'b0, 2'd2, 12'h09C, '0);           // R4 read back
        run(1'b0, 2'd0, 12'h0C4, '0);           // R2 absent granule
        run(1'b1, 2'd2, 12'h234, 32'hFFFF_FFFF); // R2 offset beyond window
        run(1'b0, 2'd1, 12'hC12, '0);           // R1 upper bits ignored
        run(1'b0, 2'd1, 12'h043, '0);           // R1 misaligned forced down
        run(1'b0, 2'd2, 12'h0A7, '0);           // R1 word alignment

        // Constrained random mix
        for (int t = 0; t < 600; t++) begin
            logic [11:0] a;
            a = 12'($urandom);
            if (($urandom % 4) != 0) a[9] = 1'b0;
            run(1'($urandom), 2'($urandom), a, $urandom);
        end

        @(negedge clk);
        chk(bad_sz == 0, "R3 native size", 32'(bad_sz), 32'd0);
        for (int i = 0; i < 512; i++)
            if (mem[i] != shadow[i]) chk(1'b0, "R7 final image", 32'(mem[i]), 32'(shadow[i]));
        chk(1'b1, "R7 final image scan", 32'd0, 32'd0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule